// File: doc/BRIEF.md
# Keyed Flash Command Register Front End

This block is the register front end of an embedded flash controller. A host reaches it over a plain 32-bit register bus with an address, a write strobe, a read strobe and write data. Read data is registered and appears the cycle after the read strobe. The block holds a mode register, a command register, a sticky status register, a result register and a write-protect register. Commands start only when they carry the command key. Each accepted command holds the controller busy for a fixed number of cycles. An internal counter produces this busy period in place of a real flash array.

The status flags are sticky, and each flag has its own clear rule. Some clear when status is read. One clears on any command write. One clears only when a programming command starts. A 16-entry lock-bit array guards the page-write and set-lock commands, and the get-lock command returns the array. Error-correction flags and the flash error are fed in on input pins. A level interrupt reports ready to the host when the interrupt is enabled.

Top module: `flash_cmd_regs`

## Requirements
- R1: After reset, status (offset 0x08) reads 0x00000001. Mode (0x00), result (0x0C) and write-protect (0xE4) read 0, and irq is 0.
- R2: A write to the command register (0x04) whose bits 31:24 are not 0x5A starts nothing, sets no flag and leaves the lock array unchanged.
- R3: A command is accepted when it carries key 0x5A, has a defined opcode, arrives while idle and is not lock-blocked. Status bit 0 then reads 0 for exactly BUSY_CYCLES cycles, starting in the cycle after the write, and then returns to 1.
- R4: A keyed command is an error if its opcode is undefined (0x06 or above 0x15) or if it arrives while busy. Such a command sets status bit 1 and starts nothing. Bit 1 is cleared by a status read or by any other command-register write.
- R5: The command argument occupies bits 23:8 and selects a page. Opcodes 0x01–0x04 and 0x08 aimed at a locked page set status bit 2 and do not run. Opcode 0x08 locks the page and 0x09 unlocks it. Opcodes 0x02 and 0x04 lock the page as they start. Opcode 0x0A loads the lock bitmap into result bits 15:0. Pages at or above 16 are never locked.
- R6: A status read returns the value held before the read. The read then clears bits 1, 2 and 16–19. A pulse on ecc_err_in[i] sets status bit 16+i.
- R7: A pulse on flash_err_in sets status bit 3, and a status read does not clear it. Bit 3 clears when a programming command is accepted (opcodes 0x01–0x05, 0x07, 0x11–0x13).
- R8: A write to mode stores only bits 0, 11:8, 16 and 26 (mask 0x04010F01). The write is ignored while protection is enabled.
- R9: A write to write-protect takes effect only when bits 31:8 equal 0x454643. It then sets the enable from bit 0. Reads return only bit 0.
- R10: irq is 1 exactly when the block is idle and mode bit 0 is 1.
- R11: The command register and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| ecc_err_in | input | 4 | Error-correction event pulses: bit 0 single low, bit 1 multiple low, bit 2 single high, bit 3 multiple high |
| flash_err_in | input | 1 | Flash error event pulse |
| irq | output | 1 | Ready interrupt |

## Verification
The hardest states to reach are the collisions between clear rules. One is a keyed command that lands while a previous command is still busy. Another is a page-write aimed at a page that an earlier command locked. A third is a flash error that must survive status reads and clear only when programming starts. Directed sequences reach these states: a second command is issued in the cycle right after the first, and set-lock, write-page and get-lock are chained in that order. Random command words are also issued, with random keys, opcodes and page arguments, plus random mode and protect writes. Each of these is checked against a bench-side model of the lock array, the mode register and the protect enable.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam logic [7:0]  OFS_MODE   = 8'h00;
  localparam logic [7:0]  OFS_CMD    = 8'h04;
  localparam logic [7:0]  OFS_STAT   = 8'h08;
  localparam logic [7:0]  OFS_RES    = 8'h0C;
  localparam logic [7:0]  OFS_PROT   = 8'hE4;
  localparam logic [7:0]  CMD_KEY    = 8'h5A;
  localparam logic [23:0] PROT_KEY   = 24'h454643;
  localparam logic [31:0] MODE_MASK  = 32'h0401_0F01;

  localparam logic [7:0] OP_WPG      = 8'h01;
  localparam logic [7:0] OP_WPG_LK   = 8'h02;
  localparam logic [7:0] OP_EWPG     = 8'h03;
  localparam logic [7:0] OP_EWPG_LK  = 8'h04;
  localparam logic [7:0] OP_ERA_ALL  = 8'h05;
  localparam logic [7:0] OP_ERA_PGS  = 8'h07;
  localparam logic [7:0] OP_LK_SET   = 8'h08;
  localparam logic [7:0] OP_LK_CLR   = 8'h09;
  localparam logic [7:0] OP_LK_GET   = 8'h0A;
  localparam logic [7:0] OP_ERA_SEC  = 8'h11;
  localparam logic [7:0] OP_USIG_WR  = 8'h12;
  localparam logic [7:0] OP_USIG_ERA = 8'h13;

  function automatic logic op_defined(input logic [7:0] op);
    return (op <= 8'h15) && (op != 8'h06);
  endfunction

  function automatic logic op_programs(input logic [7:0] op);
    return (op >= OP_WPG && op <= OP_ERA_ALL) || op == OP_ERA_PGS ||
           (op >= OP_ERA_SEC && op <= OP_USIG_ERA);
  endfunction

  function automatic logic op_lock_checked(input logic [7:0] op);
    return (op >= OP_WPG && op <= OP_EWPG_LK) || op == OP_LK_SET;
  endfunction
endpackage

// File: rtl/fcr_busy_timer.sv
module fcr_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(BUSY_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R3: the front end must never restart the timer mid-run
  a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(BUSY_CYCLES)));
endmodule

// File: rtl/fcr_lock_array.sv
module fcr_lock_array #(
  parameter int LOCK_PAGES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [15:0]           page,
  input  logic                  set_en,
  input  logic                  clr_en,
  output logic                  hit,
  output logic [LOCK_PAGES-1:0] bitmap
);
  localparam int IW = (LOCK_PAGES > 1) ? $clog2(LOCK_PAGES) : 1;
  logic in_range;
  logic [IW-1:0] idx;

  assign in_range = (32'(page) < LOCK_PAGES);
  assign idx      = page[IW-1:0];
  assign hit      = in_range && bitmap[idx];

  for (genvar g = 0; g < LOCK_PAGES; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        bitmap[g] <= 1'b0;
      else if (in_range && idx == IW'(g)) begin
        if (set_en)      bitmap[g] <= 1'b1;
        else if (clr_en) bitmap[g] <= 1'b0;
      end
    end
  end

  // R5: one lock operation per accepted command
  a_r5_one_lock_op: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));
  a_r5_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (set_en && in_range) |=> hit);
endmodule

// File: rtl/fcr_status.sv
module fcr_status (
  input  logic        clk,
  input  logic        rst,
  input  logic        busy,
  input  logic        cmd_err_set,
  input  logic        cmd_wr,
  input  logic        lock_err_set,
  input  logic        rd_clr,
  input  logic [3:0]  ecc_in,
  input  logic        flash_err_in,
  input  logic        prog_start,
  output logic [31:0] word
);
  logic       cmd_err, lock_err, flash_err;
  logic [3:0] ecc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_err   <= 1'b0;
      lock_err  <= 1'b0;
      flash_err <= 1'b0;
      ecc       <= '0;
    end else begin
      if (cmd_err_set)           cmd_err <= 1'b1;
      else if (rd_clr || cmd_wr) cmd_err <= 1'b0;
      if (lock_err_set)          lock_err <= 1'b1;
      else if (rd_clr)           lock_err <= 1'b0;
      if (flash_err_in)          flash_err <= 1'b1;
      else if (prog_start)       flash_err <= 1'b0;
      ecc <= ecc_in | (rd_clr ? 4'b0 : ecc);
    end
  end

  assign word = {12'b0, ecc, 12'b0, flash_err, lock_err, cmd_err, ~busy};

  // R6: a read with no new event leaves the read-cleared flags empty
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ecc_in == 4'b0 && !lock_err_set && !cmd_err_set)
      |=> (word[19:16] == 4'b0 && !word[2] && !word[1]));
  // R7: a programming start with no new error empties the flash error
  a_r7_prog_clears: assert property (@(posedge clk) disable iff (rst)
    (prog_start && !flash_err_in) |=> !word[3]);
  a_r7_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (word[3] && !prog_start) |=> word[3]);
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import fcr_pkg::*;
#(
  parameter int AW          = 8,
  parameter int BUSY_CYCLES = 8,
  parameter int LOCK_PAGES  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [3:0]    ecc_err_in,
  input  logic          flash_err_in,
  output logic          irq
);
  localparam int RES_PAD = 32 - LOCK_PAGES;

  logic        busy, lock_hit;
  logic        cmd_wr, keyed, op_ok, lock_bad, cmd_bad, accept;
  logic [7:0]  op;
  logic [15:0] arg;
  logic [31:0] mode_q, result_q, stat_word;
  logic        prot_en;
  logic [LOCK_PAGES-1:0] lk_map;

  assign op       = wdata[7:0];
  assign arg      = wdata[23:8];
  assign cmd_wr   = wr_en && (addr == AW'(OFS_CMD));
  assign keyed    = cmd_wr && (wdata[31:24] == CMD_KEY);
  assign op_ok    = op_defined(op);
  assign cmd_bad  = keyed && (busy || !op_ok);
  assign lock_bad = keyed && !busy && op_ok && op_lock_checked(op) && lock_hit;
  assign accept   = keyed && !busy && op_ok && !lock_bad;

  fcr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .busy(busy));

  fcr_lock_array #(.LOCK_PAGES(LOCK_PAGES)) u_locks (
    .clk(clk), .rst(rst), .page(arg),
    .set_en(accept && (op == OP_LK_SET || op == OP_WPG_LK || op == OP_EWPG_LK)),
    .clr_en(accept && op == OP_LK_CLR),
    .hit(lock_hit), .bitmap(lk_map));

  fcr_status u_status (
    .clk(clk), .rst(rst), .busy(busy),
    .cmd_err_set(cmd_bad), .cmd_wr(cmd_wr), .lock_err_set(lock_bad),
    .rd_clr(rd_en && addr == AW'(OFS_STAT)),
    .ecc_in(ecc_err_in), .flash_err_in(flash_err_in),
    .prog_start(accept && op_programs(op)), .word(stat_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      prot_en  <= 1'b0;
      result_q <= '0;
      rdata    <= '0;
    end else begin
      if (wr_en && addr == AW'(OFS_MODE) && !prot_en)
        mode_q <= wdata & MODE_MASK;
      if (wr_en && addr == AW'(OFS_PROT) && wdata[31:8] == PROT_KEY)
        prot_en <= wdata[0];
      if (accept && op == OP_LK_GET)
        result_q <= {{RES_PAD{1'b0}}, lk_map};
      if (rd_en) begin
        case (addr)
          AW'(OFS_MODE): rdata <= mode_q;
          AW'(OFS_STAT): rdata <= stat_word;
          AW'(OFS_RES):  rdata <= result_q;
          AW'(OFS_PROT): rdata <= {31'b0, prot_en};
          default:       rdata <= '0;
        endcase
      end
    end
  end

  assign irq = stat_word[0] && mode_q[0];

  // R2: an unkeyed command write leaves an idle block idle
  a_r2_badkey_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[31:24] != CMD_KEY && !busy) |=> stat_word[0]);
  // R8: mode is frozen while protection is on
  a_r8_protect_freeze: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_MODE) && prot_en) |=> $stable(mode_q));
  // R10: no ready interrupt during a busy period
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    busy |-> !irq);
  // R5: a lock-blocked command never starts the timer
  a_r5_blocked_idle: assert property (@(posedge clk) disable iff (rst)
    lock_bad |=> stat_word[0]);
endmodule

// File: tb/test_flash_cmd_regs.sv
module test_flash_cmd_regs;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  ecc_err_in = '0;
  logic        flash_err_in = 1'b0;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  logic [15:0] mlock = '0;
  logic [31:0] mmode = '0;
  logic        mprot = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_regs #(.AW(8), .BUSY_CYCLES(BUSY), .LOCK_PAGES(16)) i_flash_cmd_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ecc_err_in(ecc_err_in),
    .flash_err_in(flash_err_in), .irq(irq));

  function automatic logic defined_op(input logic [7:0] op);
    return (op <= 8'h15) && (op != 8'h06);
  endfunction
  function automatic logic checked_op(input logic [7:0] op);
    return (op >= 8'h01 && op <= 8'h04) || op == 8'h08;
  endfunction
  function automatic logic page_locked(input logic [15:0] pg);
    return (pg < 16) && mlock[pg[3:0]];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge, one cycle each
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] op, input logic [15:0] arg);
    wr(8'h04, {8'h5A, arg, op});
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4 * BUSY; i++) begin
      rd(8'h08, s);
      if (s[0]) break;
    end
  endtask
  // model update for a command expected to be accepted
  task automatic model_cmd(input logic [7:0] op, input logic [15:0] arg);
    if (arg < 16) begin
      if (op == 8'h08 || op == 8'h02 || op == 8'h04) mlock[arg[3:0]] = 1'b1;
      if (op == 8'h09) mlock[arg[3:0]] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s, r;
    int zeros;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, s); chk("R1 status", s, 32'h1);
    rd(8'h00, s); chk("R1 mode", s, 32'h0);
    rd(8'h0C, s); chk("R1 result", s, 32'h0);
    rd(8'hE4, s); chk("R1 protect", s, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R11 command and unmapped offsets read zero
    rd(8'h04, s); chk("R11 cmd reads 0", s, 32'h0);
    rd(8'h40, s); chk("R11 unmapped", s, 32'h0);

    // R8 mode mask, R10 irq
    wr(8'h00, 32'hFFFF_FFFF); mmode = 32'h0401_0F01;
    rd(8'h00, s); chk("R8 mode mask", s, mmode);
    chk("R10 irq idle enabled", {31'b0, irq}, 32'h1);

    // R3 busy length; R10 irq drops while busy
    cmd(8'h00, 16'h0);
    chk("R10 irq while busy", {31'b0, irq}, 32'h0);
    zeros = 0;
    for (int i = 0; i < 3 * BUSY; i++) begin
      rd(8'h08, s);
      if (s[0]) break;
      zeros++;
    end
    chk("R3 busy cycles", zeros, BUSY);
    chk("R10 irq after busy", {31'b0, irq}, 32'h1);

    // R2 wrong key: nothing starts, no flag, no lock change
    wr(8'h04, {8'hA5, 16'h0003, 8'h08});
    rd(8'h08, s); chk("R2 wrong key status", s, 32'h1);
    cmd(8'h0A, 16'h0); wait_idle();
    rd(8'h0C, s); chk("R2 no lock change", s, 32'h0);

    // R4 undefined opcodes, clear by read and by command write
    cmd(8'h06, 16'h0);
    rd(8'h08, s); chk("R4 op 06 error", s, 32'h3);
    rd(8'h08, s); chk("R4 cleared on read", s, 32'h1);
    cmd(8'h16, 16'h0);
    wr(8'h04, 32'h0);
    rd(8'h08, s); chk("R4 cleared by cmd write", s, 32'h1);
    // R4 keyed write while busy
    cmd(8'h00, 16'h0);
    cmd(8'h00, 16'h0);
    rd(8'h08, s); chk("R4 busy collision", s, 32'h2);
    wait_idle();

    // R5 lock path
    cmd(8'h08, 16'd3); model_cmd(8'h08, 16'd3); wait_idle();
    cmd(8'h0A, 16'h0); wait_idle();
    rd(8'h0C, s); chk("R5 lock bitmap", s, 32'h0000_0008);
    cmd(8'h01, 16'd3);
    rd(8'h08, s); chk("R5 locked page blocked", s, 32'h5);
    rd(8'h08, s); chk("R5 lock err read-clear", s, 32'h1);
    cmd(8'h09, 16'd3); model_cmd(8'h09, 16'd3); wait_idle();
    cmd(8'h02, 16'd5); model_cmd(8'h02, 16'd5); wait_idle();
    cmd(8'h0A, 16'h0); wait_idle();
    rd(8'h0C, s); chk("R5 write-and-lock", s, 32'h0000_0020);
    cmd(8'h08, 16'd20); wait_idle();
    cmd(8'h0A, 16'h0); wait_idle();
    rd(8'h0C, s); chk("R5 out-of-range page", s, 32'h0000_0020);

    // R6 error-correction flags
    ecc_err_in = 4'b1011; @(negedge clk); ecc_err_in = 4'b0;
    rd(8'h08, s); chk("R6 ecc set", s, 32'h000B_0001);
    rd(8'h08, s); chk("R6 ecc read-clear", s, 32'h1);

    // R7 flash error
    flash_err_in = 1'b1; @(negedge clk); flash_err_in = 1'b0;
    rd(8'h08, s); chk("R7 flash err set", s, 32'h9);
    rd(8'h08, s); chk("R7 survives read", s, 32'h9);
    cmd(8'h0A, 16'h0); wait_idle();
    rd(8'h08, s); chk("R7 non-prog keeps", s, 32'h9);
    cmd(8'h01, 16'd1); wait_idle();
    rd(8'h08, s); chk("R7 prog clears", s, 32'h1);

    // R9 protect key
    wr(8'hE4, {24'h123456, 8'h01});
    rd(8'hE4, s); chk("R9 wrong key", s, 32'h0);
    wr(8'hE4, {24'h454643, 8'hFF}); mprot = 1'b1;
    rd(8'hE4, s); chk("R9 enable", s, 32'h1);
    wr(8'h00, 32'h0);
    rd(8'h00, s); chk("R8 protected mode write", s, mmode);
    wr(8'hE4, {24'h454643, 8'h00}); mprot = 1'b0;

    // random mix against bench model
    for (int it = 0; it < 300; it++) begin
      int kind;
      kind = $urandom_range(0, 3);
      if (kind == 0) begin
        r = $urandom;
        wr(8'h00, r);
        if (!mprot) mmode = r & 32'h0401_0F01;
        rd(8'h00, s); chk("R8 random mode", s, mmode);
      end else if (kind == 1) begin
        logic ok;
        ok = $urandom_range(0, 1);
        r = {ok ? 24'h454643 : 24'($urandom), 7'($urandom), 1'($urandom)};
        wr(8'hE4, r);
        if (r[31:8] == 24'h454643) mprot = r[0];
        rd(8'hE4, s); chk("R9 random protect", s, {31'b0, mprot});
      end else if (kind == 2) begin
        logic [7:0] k;
        k = 8'($urandom);
        if (k == 8'h5A) k = 8'h00;
        wr(8'h04, {k, 16'($urandom), 8'($urandom_range(0, 23))});
        rd(8'h08, s); chk("R2 random bad key", s, 32'h1);
      end else begin
        logic [7:0]  op;
        logic [15:0] pg;
        op = 8'($urandom_range(0, 23));
        pg = 16'($urandom_range(0, 19));
        cmd(op, pg);
        rd(8'h08, s);
        if (!defined_op(op))
          chk("R4 random opcode", s, 32'h3);
        else if (checked_op(op) && page_locked(pg))
          chk("R5 random locked", s, 32'h5);
        else begin
          chk("R3 random accept", s, 32'h0);
          model_cmd(op, pg);
          wait_idle();
          if (op == 8'h0A) begin
            rd(8'h0C, s); chk("R5 random bitmap", s, {16'b0, mlock});
          end
        end
      end
    end

    cmd(8'h0A, 16'h0); wait_idle();
    rd(8'h0C, s); chk("R5 final bitmap", s, {16'b0, mlock});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule